// File: doc/BRIEF.md
# Dual-Lane Accumulator Interpolator

This unit is a small memory-mapped helper for address generation and table stepping. It has two lanes. Each lane keeps a 32-bit accumulator, a 32-bit base and a 16-bit control word. A lane's raw value is its accumulator rotated right, cut down to a contiguous bit field, and optionally sign-extended from the top of that field. The lane result is the raw value plus the lane base. A third base register is added to both raw values to form a combined result.

Software reads results through six view addresses. A peek view returns a value and changes nothing. A pop view returns the same value and, at the clock edge that ends the access, loads each lane's own result into that lane's accumulator. This lets a loop step both lanes with one read. Add ports give a single-cycle read-modify-write on an accumulator. A packed write loads both lane bases from the two halves of one word. Each half is extended to 32 bits according to that lane's signed flag.

Read data is combinational during a read access (select high, write low). Every state change takes effect at the rising clock edge that ends the access.

Top module: `interp_unit`

## Requirements
- R1: After reset (active-low `rst_n`), all accumulators, bases and control words are zero. `bus_rdata` is zero whenever no read access is active.
- R2: Word address map: 0 ACC0, 1 ACC1, 2 BASE0, 3 BASE1, 4 BASE2, 5 POP0, 6 POP1, 7 POPF, 8 PEEK0, 9 PEEK1, 10 PEEKF, 11 CTRL0, 12 CTRL1, 13 ADD0, 14 ADD1, 15 BASEPK. ACCx, BASEx and CTRLx read back what was last written to them. CTRLx keeps bits 15:0 and reads zero above them. BASEPK reads zero.
- R3: Control word fields: bits 4:0 rotate amount, bits 9:5 field low index, bits 14:10 field high index, bit 15 signed. The raw value is the accumulator rotated right by the rotate amount, keeping bits low..high and clearing the rest. When signed is set and bit `high` of that value is 1, all bits above `high` are set. Reading ADDx returns lane x's raw value.
- R4: Reading PEEK0 or PEEK1 returns that lane's raw value plus its base, modulo 2^32.
- R5: Reading PEEKF returns BASE2 + raw0 + raw1, modulo 2^32.
- R6: A read of any address other than a pop view changes no accumulator.
- R7: A read of POP0, POP1 or POPF returns the same value as the matching peek view. At the end of the access, ACC0 takes lane 0's result and ACC1 takes lane 1's result, both computed from the values before the access.
- R8: Writing ADDx sets ACCx to ACCx + data, modulo 2^32. The other lane is unaffected.
- R9: Writing BASEPK loads BASE0 from data bits 15:0 and BASE1 from bits 31:16 in the same cycle. Each half is sign-extended when that lane's signed bit is set, and zero-extended otherwise.
- R10: When the field low index exceeds the high index, the raw value is zero, even with signed set.
- R11: Writes to the six view addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access in progress this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |

## Verification
The bench targets several corner cases.
- **Pop timing.** A pop must return the pre-update value, and it must load both accumulators, not only the selected lane. A design that updated before driving data, or that loaded only one lane, returns or leaves the wrong accumulator.
- **Rotate edges.** Rotation by 0 and by 31, and a field reaching bit 31, expose shift-versus-rotate slips and off-by-one mask arithmetic.
- **Sign handling.** Signed fields with the top bit set and clear, and an inverted field range, catch sign extension from the wrong bit or from an empty field.
- **Packed base and wrap.** A packed base with one signed and one unsigned lane catches a swapped or shared signed flag. An add that carries past bit 31 and writes to view addresses catch stray updates.

// File: rtl/interp_pkg.sv
package interp_pkg;
  localparam int XLEN   = 32;
  localparam int SH_W   = $clog2(XLEN);
  localparam int CTRL_W = 16;
  localparam int HALF_W = XLEN / 2;
  localparam int ADDR_W = 4;
  localparam int NLANES = 2;

  typedef struct packed {
    logic            sgn;
    logic [SH_W-1:0] hi;
    logic [SH_W-1:0] lo;
    logic [SH_W-1:0] rot;
  } lane_ctrl_t;

  typedef enum logic [ADDR_W-1:0] {
    A_ACC0  = 4'd0,  A_ACC1  = 4'd1,  A_BASE0 = 4'd2,  A_BASE1 = 4'd3,
    A_BASE2 = 4'd4,  A_POP0  = 4'd5,  A_POP1  = 4'd6,  A_POPF  = 4'd7,
    A_PEEK0 = 4'd8,  A_PEEK1 = 4'd9,  A_PEEKF = 4'd10, A_CTRL0 = 4'd11,
    A_CTRL1 = 4'd12, A_ADD0  = 4'd13, A_ADD1  = 4'd14, A_BASEPK = 4'd15
  } addr_e;

  function automatic logic [XLEN-1:0] rot_right(input logic [XLEN-1:0] v,
                                                input logic [SH_W-1:0] s);
    logic [2*XLEN-1:0] t;
    t = {v, v} >> s;
    return t[XLEN-1:0];
  endfunction

  function automatic logic [XLEN-1:0] field_mask(input logic [SH_W-1:0] lo,
                                                 input logic [SH_W-1:0] hi);
    logic [XLEN-1:0] upto, from;
    upto = {XLEN{1'b1}} >> (SH_W'(XLEN - 1) - hi);
    from = {XLEN{1'b1}} << lo;
    return upto & from;
  endfunction

  function automatic logic [XLEN-1:0] lane_raw(input logic [XLEN-1:0] acc,
                                               input lane_ctrl_t c);
    logic [XLEN-1:0] upto, m;
    upto = {XLEN{1'b1}} >> (SH_W'(XLEN - 1) - c.hi);
    m    = rot_right(acc, c.rot) & field_mask(c.lo, c.hi);
    if (c.sgn && m[c.hi]) m = m | ~upto;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] ext_half(input logic [HALF_W-1:0] h,
                                               input logic sgn);
    return {{HALF_W{sgn & h[HALF_W-1]}}, h};
  endfunction
endpackage

// File: rtl/interp_decode.sv
module interp_decode
  import interp_pkg::*;
(
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic [NLANES-1:0] wr_acc,
  output logic [NLANES-1:0] wr_base,
  output logic [NLANES-1:0] wr_ctrl,
  output logic [NLANES-1:0] add_acc,
  output logic              wr_base2,
  output logic              wr_pk,
  output logic              rd_any,
  output logic              pop_rd,
  output logic              peek_rd
);
  logic wr;
  assign wr     = sel & we;
  assign rd_any = sel & ~we;

  always_comb begin
    wr_acc   = '0;
    wr_base  = '0;
    wr_ctrl  = '0;
    add_acc  = '0;
    wr_base2 = 1'b0;
    wr_pk    = 1'b0;
    if (wr) begin
      unique case (addr_e'(addr))
        A_ACC0:   wr_acc[0]  = 1'b1;
        A_ACC1:   wr_acc[1]  = 1'b1;
        A_BASE0:  wr_base[0] = 1'b1;
        A_BASE1:  wr_base[1] = 1'b1;
        A_BASE2:  wr_base2   = 1'b1;
        A_CTRL0:  wr_ctrl[0] = 1'b1;
        A_CTRL1:  wr_ctrl[1] = 1'b1;
        A_ADD0:   add_acc[0] = 1'b1;
        A_ADD1:   add_acc[1] = 1'b1;
        A_BASEPK: wr_pk      = 1'b1;
        default:  ;
      endcase
    end
  end

  assign pop_rd  = rd_any & (addr == A_POP0  || addr == A_POP1  || addr == A_POPF);
  assign peek_rd = rd_any & (addr == A_PEEK0 || addr == A_PEEK1 || addr == A_PEEKF);
endmodule

// File: rtl/interp_lane.sv
module interp_lane
  import interp_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic              wr_base,
  input  logic              wr_ctrl,
  input  logic              add_acc,
  input  logic              wr_pk,
  input  logic              pop_load,
  input  logic [XLEN-1:0]   wdata,
  input  logic [HALF_W-1:0] pk_half,
  output logic [XLEN-1:0]   acc_q,
  output logic [XLEN-1:0]   base_q,
  output lane_ctrl_t        ctrl_q,
  output logic [XLEN-1:0]   raw,
  output logic [XLEN-1:0]   result
);
  assign raw    = lane_raw(acc_q, ctrl_q);
  assign result = raw + base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      base_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (pop_load)     acc_q <= result;
      else if (add_acc) acc_q <= acc_q + wdata;
      else if (wr_acc)  acc_q <= wdata;
      if (wr_pk)        base_q <= ext_half(pk_half, ctrl_q.sgn);
      else if (wr_base) base_q <= wdata;
      if (wr_ctrl)      ctrl_q <= lane_ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  // R7: a pop loads the pre-access result
  p_pop_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_load |=> acc_q == $past(result));
  // R8: add port wraps modulo 2^32
  p_add_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    add_acc |=> acc_q == $past(acc_q) + $past(wdata));
  // R6 / R11: no accumulator strobe, no change
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_load || add_acc || wr_acc) |=> $stable(acc_q));
  // R9: packed half extension follows the signed flag
  p_pk_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pk && ctrl_q.sgn) |=> base_q[XLEN-1:HALF_W] == {HALF_W{base_q[HALF_W-1]}});
  p_pk_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pk && !ctrl_q.sgn) |=> base_q[XLEN-1:HALF_W] == '0);
endmodule

// File: rtl/interp_unit.sv
module interp_unit
  import interp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [XLEN-1:0]   bus_wdata,
  output logic [XLEN-1:0]   bus_rdata
);
  logic [NLANES-1:0] wr_acc, wr_base, wr_ctrl, add_acc;
  logic              wr_base2, wr_pk, rd_any, pop_rd, peek_rd;
  logic [XLEN-1:0]   acc_q  [NLANES];
  logic [XLEN-1:0]   base_q [NLANES];
  lane_ctrl_t        ctrl_q [NLANES];
  logic [XLEN-1:0]   raw    [NLANES];
  logic [XLEN-1:0]   result [NLANES];
  logic [XLEN-1:0]   base2_q;
  logic [XLEN-1:0]   full;

  interp_decode u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wr_acc(wr_acc), .wr_base(wr_base), .wr_ctrl(wr_ctrl), .add_acc(add_acc),
    .wr_base2(wr_base2), .wr_pk(wr_pk), .rd_any(rd_any),
    .pop_rd(pop_rd), .peek_rd(peek_rd)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    interp_lane #(.LANE(g)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .wr_acc(wr_acc[g]), .wr_base(wr_base[g]), .wr_ctrl(wr_ctrl[g]),
      .add_acc(add_acc[g]), .wr_pk(wr_pk), .pop_load(pop_rd),
      .wdata(bus_wdata), .pk_half(bus_wdata[HALF_W*g +: HALF_W]),
      .acc_q(acc_q[g]), .base_q(base_q[g]), .ctrl_q(ctrl_q[g]),
      .raw(raw[g]), .result(result[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base2_q <= '0;
    else if (wr_base2) base2_q <= bus_wdata;
  end

  assign full = base2_q + raw[0] + raw[1];

  always_comb begin
    bus_rdata = '0;
    if (rd_any) begin
      unique case (addr_e'(bus_addr))
        A_ACC0:  bus_rdata = acc_q[0];
        A_ACC1:  bus_rdata = acc_q[1];
        A_BASE0: bus_rdata = base_q[0];
        A_BASE1: bus_rdata = base_q[1];
        A_BASE2: bus_rdata = base2_q;
        A_POP0, A_PEEK0: bus_rdata = result[0];
        A_POP1, A_PEEK1: bus_rdata = result[1];
        A_POPF, A_PEEKF: bus_rdata = full;
        A_CTRL0: bus_rdata = XLEN'(ctrl_q[0]);
        A_CTRL1: bus_rdata = XLEN'(ctrl_q[1]);
        A_ADD0:  bus_rdata = raw[0];
        A_ADD1:  bus_rdata = raw[1];
        default: bus_rdata = '0;
      endcase
    end
  end

  // R2: at most one state strobe per access
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_acc, wr_base, wr_ctrl, add_acc, wr_base2, wr_pk, pop_rd}));
  // R6: peek reads leave both accumulators alone
  p_peek_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    peek_rd |=> ($stable(acc_q[0]) && $stable(acc_q[1])));
  // R1: idle bus returns zero
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |-> bus_rdata == '0);
  // R7: pop loads both lanes together
  p_pop_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_rd |=> (acc_q[0] == $past(result[0]) && acc_q[1] == $past(result[1])));
endmodule

// File: tb/test_interp_unit.sv
module test_interp_unit;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_acc  [2];
  logic [31:0] m_base [3];
  logic [15:0] m_ctrl [2];

  interp_unit i_interp_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] m_raw(input int l);
    int sh, lo, hi;
    logic [31:0] r;
    sh = int'(m_ctrl[l][4:0]);
    lo = int'(m_ctrl[l][9:5]);
    hi = int'(m_ctrl[l][14:10]);
    r = '0;
    for (int i = 0; i < 32; i++)
      if (i >= lo && i <= hi) r[i] = m_acc[l][(i + sh) % 32];
    if (m_ctrl[l][15] && lo <= hi && r[hi])
      for (int i = 0; i < 32; i++) if (i > hi) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] m_res(input int l);
    return m_raw(l) + m_base[l];
  endfunction

  function automatic logic [31:0] m_full();
    return m_base[2] + m_raw(0) + m_raw(1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    case (a)
      4'd0: m_acc[0] = d;
      4'd1: m_acc[1] = d;
      4'd2: m_base[0] = d;
      4'd3: m_base[1] = d;
      4'd4: m_base[2] = d;
      4'd11: m_ctrl[0] = d[15:0];
      4'd12: m_ctrl[1] = d[15:0];
      4'd13: m_acc[0] = m_acc[0] + d;
      4'd14: m_acc[1] = m_acc[1] + d;
      4'd15: begin
        m_base[0] = {{16{m_ctrl[0][15] & d[15]}}, d[15:0]};
        m_base[1] = {{16{m_ctrl[1][15] & d[31]}}, d[31:16]};
      end
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    logic [31:0] r0, r1;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #(CLK_P/4);
    v = bus_rdata;
    r0 = m_res(0); r1 = m_res(1);
    @(negedge clk);
    bus_sel = 1'b0;
    if (a >= 4'd5 && a <= 4'd7) begin m_acc[0] = r0; m_acc[1] = r1; end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    #(CLK_P/4);
    check("R1 idle rdata", bus_rdata, 32'h0);
    rd(4'd0, v);  check("R1 acc0 reset", v, 32'h0);
    rd(4'd1, v);  check("R1 acc1 reset", v, 32'h0);
    rd(4'd12, v); check("R1 ctrl1 reset", v, 32'h0);
    rd(4'd10, v); check("R1 peekf reset", v, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    wr(4'd0, 32'h1234_5678); rd(4'd0, v); check("R2 acc0 rw", v, 32'h1234_5678);
    wr(4'd4, 32'hCAFE_0001); rd(4'd4, v); check("R2 base2 rw", v, 32'hCAFE_0001);
    wr(4'd11, 32'hFFFF_A5C3); rd(4'd11, v); check("R2 ctrl0 rw", v, 32'h0000_A5C3);
    rd(4'd15, v); check("R2 basepk reads zero", v, 32'h0);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    wr(4'd0, 32'h1234_5678);
    wr(4'd11, {16'h0, 1'b0, 5'd7, 5'd0, 5'd4});
    rd(4'd13, v); check("R3 rot4 byte", v, 32'h0000_0067);
    wr(4'd11, {16'h0, 1'b0, 5'd31, 5'd0, 5'd0});
    rd(4'd13, v); check("R3 rot0 full", v, m_raw(0));
    wr(4'd11, {16'h0, 1'b0, 5'd31, 5'd0, 5'd31});
    rd(4'd13, v); check("R3 rot31", v, 32'h2468_ACF0);
    wr(4'd0, 32'h0000_00F0);
    wr(4'd11, {16'h0, 1'b1, 5'd3, 5'd0, 5'd4});
    rd(4'd13, v); check("R3 signed neg", v, 32'hFFFF_FFFF);
    wr(4'd11, {16'h0, 1'b1, 5'd4, 5'd0, 5'd4});
    rd(4'd13, v); check("R3 signed pos", v, 32'h0000_000F);
    wr(4'd1, 32'h8000_0000);
    wr(4'd12, {16'h0, 1'b1, 5'd31, 5'd28, 5'd0});
    rd(4'd14, v); check("R3 lane1 top field", v, m_raw(1));
  endtask

  task automatic t_empty();
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd11, {16'h0, 1'b1, 5'd3, 5'd9, 5'd0});
    rd(4'd13, v); check("R10 empty field", v, 32'h0);
  endtask

  task automatic t_results();
    logic [31:0] v;
    wr(4'd0, 32'h0000_0ABC);
    wr(4'd11, {16'h0, 1'b0, 5'd11, 5'd4, 5'd0});
    wr(4'd2, 32'h1000_0000);
    wr(4'd1, 32'hF000_0003);
    wr(4'd12, {16'h0, 1'b1, 5'd3, 5'd0, 5'd28});
    wr(4'd3, 32'h0000_0100);
    wr(4'd4, 32'hFFFF_FFF0);
    rd(4'd8, v);  check("R4 peek0", v, m_res(0));
    rd(4'd9, v);  check("R4 peek1", v, m_res(1));
    rd(4'd10, v); check("R5 peekf", v, m_full());
    rd(4'd0, v);  check("R6 acc0 after peeks", v, 32'h0000_0ABC);
    rd(4'd1, v);  check("R6 acc1 after peeks", v, 32'hF000_0003);
  endtask

  task automatic t_pop();
    logic [31:0] v, e0, e1, ef;
    e0 = m_res(0); e1 = m_res(1);
    rd(4'd5, v); check("R7 pop0 value", v, e0);
    rd(4'd0, v); check("R7 acc0 loaded", v, e0);
    rd(4'd1, v); check("R7 acc1 loaded", v, e1);
    e1 = m_res(1);
    rd(4'd6, v); check("R7 pop1 value", v, e1);
    ef = m_full();
    rd(4'd7, v); check("R7 popf value", v, ef);
    rd(4'd1, v); check("R7 acc1 after popf", v, m_acc[1]);
  endtask

  task automatic t_add();
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFF0);
    wr(4'd1, 32'h0000_0005);
    wr(4'd13, 32'h0000_0020);
    rd(4'd0, v); check("R8 add wrap", v, 32'h0000_0010);
    rd(4'd1, v); check("R8 other lane", v, 32'h0000_0005);
    wr(4'd14, 32'h8000_0000);
    rd(4'd1, v); check("R8 add lane1", v, 32'h8000_0005);
  endtask

  task automatic t_pk();
    logic [31:0] v;
    wr(4'd11, {16'h0, 1'b1, 15'h0});
    wr(4'd12, 32'h0);
    wr(4'd15, 32'h8001_F00F);
    rd(4'd2, v); check("R9 base0 signed", v, 32'hFFFF_F00F);
    rd(4'd3, v); check("R9 base1 unsigned", v, 32'h0000_8001);
    wr(4'd11, 32'h0);
    wr(4'd12, {16'h0, 1'b1, 15'h0});
    wr(4'd15, 32'h9000_8000);
    rd(4'd2, v); check("R9 base0 zero ext", v, 32'h0000_8000);
    rd(4'd3, v); check("R9 base1 sign ext", v, 32'hFFFF_9000);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    wr(4'd0, 32'h0000_1111);
    wr(4'd1, 32'h0000_2222);
    for (int a = 5; a <= 10; a++) wr(4'(a), 32'hDEAD_BEEF);
    rd(4'd0, v); check("R11 acc0 kept", v, 32'h0000_1111);
    rd(4'd1, v); check("R11 acc1 kept", v, 32'h0000_2222);
    rd(4'd2, v); check("R11 base0 kept", v, m_base[0]);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ctrl[i] = '0; end
    for (int i = 0; i < 3; i++) m_base[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_raw();
    t_empty();
    t_results();
    t_pop();
    t_add();
    t_pk();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule